// File: doc/BRIEF.md
# Phase-Shifted Carrier Gate Modulator for a Seven-Switch Five-Level Leg

This block turns a signed reference sample into the seven gate commands of one single-phase five-level leg. The leg has two outer switches, a complementary inner pair, a clamp switch and a pair of line-frequency switches. Two triangular carriers run from 0 to a programmable peak and sit half a switching period apart. The carrier that starts at the bottom drives the outer switches and the clamp switch. The carrier that starts at the top drives the inner pair. The line-frequency pair follows a latched output-current polarity bit.

The reference is a two's complement fraction. A sample at or above zero is compared directly. A negative sample is lifted by one full scale, so the comparison value stays between 0 and the carrier peak. The reference, the polarity bit and the period setting are taken only when the first carrier is at its valley, so a switching period always uses one consistent set of inputs.

Each gate vector is decoded into a three-bit state code. A vector that is not one of the eight legal combinations raises a fault flag for that cycle and turns all gates off.

Top module: `pspwm_gate_gen`

## Requirements
- R1: While `rst_n` is low, `gate_o`, `state_o` and `fault_o` are all zero.
- R2: Carrier 1 starts at 0 and rises by one per clock to the peak P, then falls by one per clock back to 0, so one period is 2P clocks. P is `period_i` at the valley, raised to 2 if it is smaller. Carrier 2 always equals P minus carrier 1. All outputs are registered and reflect the carrier and latched values of the previous cycle.
- R3: The half-cycle is positive when the latched reference sign bit is 0. The comparison value is floor(L * P / 2^(RW-1)), where L is the reference with its sign bit dropped. For a negative sample, L equals the sample plus one full scale.
- R4: Bit 6 of `gate_o` (outer upper switch) is on when the half-cycle is positive and the comparison value exceeds carrier 1. Bit 3 (outer lower switch) is on when the half-cycle is negative and the comparison value is below carrier 1. The two are never on together.
- R5: Bit 0 of `gate_o` (clamp switch) is on exactly when bits 6 and 3 are both off.
- R6: Bit 5 of `gate_o` is on when the comparison value exceeds carrier 2. Bit 4 is its complement.
- R7: Bit 1 of `gate_o` is on when the latched polarity bit is 0 (positive current). Bit 2 is on when it is 1.
- R8: `ref_i`, `cur_neg_i` and `period_i` are sampled only in a cycle where carrier 1 is 0. Values presented in any other cycle have no effect on the outputs.
- R9: `state_o` reports the legal gate vector (bits 6..0) as follows: 0=1100010, 1=1010010, 2=0100011, 3=0010011, 4=0100101, 5=0010101, 6=0101100, 7=0011100.
- R10: Any other gate vector drives `fault_o` to 1, `gate_o` to 0 and `state_o` to 0 for that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_i | input | RW | Signed reference fraction, full scale 2^(RW-1) |
| cur_neg_i | input | 1 | Output-current polarity, 1 = negative |
| period_i | input | CW | Carrier peak count P (minimum 2) |
| gate_o | output | 7 | Gate commands, bit 6 = outer upper switch … bit 0 = clamp switch |
| state_o | output | 3 | Decoded switching-state code |
| fault_o | output | 1 | Illegal gate vector seen |

## Verification
The bench sweeps the reference across the full signed range, including the extreme codes, zero and minus one. It does this for four carrier peaks, including the minimum of 2, and for both current polarities. It compares every cycle against an arithmetic model. In every cycle that is not a valley, it drives complemented reference, polarity and period values. A design that sampled its inputs mid-period, or that derived the second carrier with an off-by-one, would show the wrong inner-pair edges within a few cycles. Mismatched reference sign and current polarity produce illegal vectors. A design that let such a vector through, or that mixed up the offset for negative references, would fail the fault and state-code checks. The bench also confirms that all eight state codes and the fault condition actually occur during the sweep.

// File: rtl/pspwm_gate_gen.sv
module pspwm_gate_gen #(
  parameter int CW   = 16,
  parameter int RW   = 16,
  parameter int PMIN = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [RW-1:0] ref_i,
  input  logic                 cur_neg_i,
  input  logic [CW-1:0]        period_i,
  output logic [6:0]           gate_o,
  output logic [2:0]           state_o,
  output logic                 fault_o
);
  localparam int FW = RW - 1;
  localparam int PW = FW + CW;

  logic [CW-1:0]        c1_q, pk_q;
  logic                 up_q, cur_q;
  logic signed [RW-1:0] ref_q;

  logic          valley, neg_half;
  logic [CW-1:0] pk_new, c2, cmp;
  logic [PW-1:0] prod;
  logic [6:0]    raw;
  logic [2:0]    code;
  logic          legal;

  assign valley   = (c1_q == '0);
  assign pk_new   = (period_i < CW'(PMIN)) ? CW'(PMIN) : period_i;
  assign c2       = pk_q - c1_q;
  assign neg_half = ref_q[RW-1];
  assign prod     = PW'(ref_q[FW-1:0]) * PW'(pk_q);
  assign cmp      = CW'(prod >> FW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c1_q  <= '0;
      up_q  <= 1'b1;
      pk_q  <= CW'(PMIN);
      ref_q <= '0;
      cur_q <= 1'b0;
    end else if (valley) begin
      c1_q  <= CW'(1);
      up_q  <= 1'b1;
      pk_q  <= pk_new;
      ref_q <= ref_i;
      cur_q <= cur_neg_i;
    end else if (up_q) begin
      c1_q <= c1_q + CW'(1);
      up_q <= (c1_q + CW'(1)) != pk_q;
    end else begin
      c1_q <= c1_q - CW'(1);
    end
  end

  logic t1, t4;
  assign t1  = !neg_half && (cmp > c1_q);
  assign t4  = neg_half && (cmp < c1_q);
  assign raw = {t1, (cmp > c2), !(cmp > c2), t4, cur_q, !cur_q, !(t1 || t4)};

  always_comb begin
    legal = 1'b1;
    code  = 3'd0;
    case (raw)
      7'b1100010: code = 3'd0;
      7'b1010010: code = 3'd1;
      7'b0100011: code = 3'd2;
      7'b0010011: code = 3'd3;
      7'b0100101: code = 3'd4;
      7'b0010101: code = 3'd5;
      7'b0101100: code = 3'd6;
      7'b0011100: code = 3'd7;
      default:    legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_o  <= '0;
      state_o <= '0;
      fault_o <= 1'b0;
    end else begin
      gate_o  <= legal ? raw : 7'd0;
      state_o <= legal ? code : 3'd0;
      fault_o <= !legal;
    end
  end
endmodule

// File: rtl/pspwm_gate_gen_chk.sv
module pspwm_gate_gen_chk #(
  parameter int CW   = 16,
  parameter int RW   = 16,
  parameter int PMIN = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [6:0]           gate_o,
  input logic [2:0]           state_o,
  input logic                 fault_o,
  input logic [CW-1:0]        c1_q,
  input logic [CW-1:0]        pk_q,
  input logic signed [RW-1:0] ref_q,
  input logic                 cur_q,
  input logic                 valley
);
  function automatic logic [6:0] vec_of(input logic [2:0] s);
    case (s)
      3'd0: vec_of = 7'b1100010;
      3'd1: vec_of = 7'b1010010;
      3'd2: vec_of = 7'b0100011;
      3'd3: vec_of = 7'b0010011;
      3'd4: vec_of = 7'b0100101;
      3'd5: vec_of = 7'b0010101;
      3'd6: vec_of = 7'b0101100;
      default: vec_of = 7'b0011100;
    endcase
  endfunction

  p_carrier_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (c1_q <= pk_q) && (pk_q >= CW'(PMIN)));

  p_outer_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_o[6] && gate_o[3]));

  p_clamp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o != 7'd0) |-> (gate_o[0] == !(gate_o[6] || gate_o[3])));

  p_inner_compl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o != 7'd0) |-> (gate_o[5] != gate_o[4]));

  p_line_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o != 7'd0) |-> ($countones(gate_o[2:1]) == 1));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valley |=> ($stable(ref_q) && $stable(cur_q) && $stable(pk_q)));

  p_state_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_o && gate_o != 7'd0) |-> (gate_o == vec_of(state_o)));

  p_fault_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> (gate_o == 7'd0 && state_o == 3'd0));
endmodule

bind pspwm_gate_gen pspwm_gate_gen_chk #(.CW(CW), .RW(RW), .PMIN(PMIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate_o(gate_o), .state_o(state_o), .fault_o(fault_o),
  .c1_q(c1_q), .pk_q(pk_q), .ref_q(ref_q), .cur_q(cur_q), .valley(valley)
);

// File: tb/sim_pspwm_gate_gen.sv
`timescale 1ns/1ps
module sim_pspwm_gate_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [15:0] ref_i = '0;
  logic cur_neg_i = 1'b0;
  logic [15:0] period_i = '0;
  logic [6:0] gate_o;
  logic [2:0] state_o;
  logic fault_o;

  pspwm_gate_gen u0 (.clk(clk), .rst_n(rst_n), .ref_i(ref_i), .cur_neg_i(cur_neg_i),
                     .period_i(period_i), .gate_o(gate_o), .state_o(state_o), .fault_o(fault_o));

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  int m_c1, m_pk;
  bit m_up, m_cur;
  int m_ref;
  logic [6:0] e_gate;
  logic [2:0] e_state;
  bit e_fault, have_exp;
  bit [7:0] seen_state;
  bit seen_fault;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit lookup(input logic [6:0] v, output logic [2:0] s);
    lookup = 1'b1;
    s = 3'd0;
    case (v)
      7'b1100010: s = 3'd0;
      7'b1010010: s = 3'd1;
      7'b0100011: s = 3'd2;
      7'b0010011: s = 3'd3;
      7'b0100101: s = 3'd4;
      7'b0010101: s = 3'd5;
      7'b0101100: s = 3'd6;
      7'b0011100: s = 3'd7;
      default: lookup = 1'b0;
    endcase
  endfunction

  task automatic model_reset();
    m_c1 = 0; m_up = 1; m_pk = 2; m_ref = 0; m_cur = 0; have_exp = 0;
  endtask

  task automatic prep(input int r, input bit c, input int p);
    longint low, cmp;
    bit neg, g1, g2, g4;
    logic [6:0] v;
    logic [2:0] s;
    neg = (m_ref < 0);
    low = neg ? m_ref + 32768 : m_ref;
    cmp = (low * m_pk) / 32768;
    g1 = !neg && (cmp > m_c1);
    g4 = neg && (cmp < m_c1);
    g2 = cmp > (m_pk - m_c1);
    v = {g1, g2, !g2, g4, m_cur, !m_cur, !(g1 || g4)};
    if (lookup(v, s)) begin e_gate = v; e_state = s; e_fault = 0; end
    else begin e_gate = 0; e_state = 0; e_fault = 1; end
    have_exp = 1;
    if (m_c1 == 0) begin
      ref_i = 16'(r); cur_neg_i = c; period_i = 16'(p);
      m_pk = (p < 2) ? 2 : p; m_ref = r; m_cur = c; m_c1 = 1; m_up = 1;
    end else begin
      ref_i = ~16'(r); cur_neg_i = ~c; period_i = ~16'(p);
      if (m_up) begin m_c1++; if (m_c1 == m_pk) m_up = 0; end
      else m_c1--;
    end
  endtask

  task automatic cycle(input int r, input bit c, input int p);
    @(negedge clk);
    if (have_exp) begin
      if (e_fault) begin
        chk(fault_o == 1'b1 && gate_o == 7'd0 && state_o == 3'd0, "R10 fault forces gates off",
            {gate_o, state_o, fault_o}, {e_gate, e_state, e_fault});
      end else begin
        chk({gate_o[6], gate_o[3]} == {e_gate[6], e_gate[3]}, "R2 R3 R8 R4 outer switches",
            gate_o, e_gate);
        chk(gate_o[0] == e_gate[0], "R5 clamp switch", gate_o, e_gate);
        chk(gate_o[5:4] == e_gate[5:4], "R2 R3 R8 R6 inner pair", gate_o, e_gate);
        chk(gate_o[2:1] == e_gate[2:1], "R8 R7 line pair", gate_o, e_gate);
        chk(state_o == e_state, "R9 state code", state_o, e_state);
        chk(fault_o == 1'b0, "R10 no fault on legal vector", fault_o, 0);
        seen_state[state_o] = 1'b1;
      end
      if (fault_o) seen_fault = 1'b1;
    end
    prep(r, c, p);
  endtask

  initial begin
    int per;
    model_reset();
    seen_state = '0;
    seen_fault = 0;
    repeat (3) @(negedge clk);
    chk(gate_o == 7'd0 && state_o == 3'd0 && fault_o == 1'b0, "R1 reset outputs",
        {gate_o, state_o, fault_o}, 0);
    rst_n = 1'b1;
    prep(0, 0, 2);
    for (int pi = 0; pi < 4; pi++) begin
      case (pi) 0: per = 2; 1: per = 3; 2: per = 5; default: per = 8; endcase
      for (int k = 0; k < 34; k++) begin
        int r;
        r = (k < 32) ? k * 2048 - 32768 : ((k == 32) ? 32767 : -1);
        for (int c = 0; c < 2; c++)
          for (int n = 0; n < 4 * per + 2; n++) cycle(r, c[0], per);
      end
    end
    for (int n = 0; n < 12; n++) cycle(12000, 0, 0);
    chk(seen_state == 8'hFF, "R9 all eight states reached", seen_state, 8'hFF);
    chk(seen_fault, "R10 illegal vector reached", seen_fault, 1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(gate_o == 7'd0 && state_o == 3'd0 && fault_o == 1'b0, "R1 reset mid-run",
        {gate_o, state_o, fault_o}, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired (all requirements) actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule